// File: doc/BRIEF.md
# Exact-Ratio Trigonometric Triple Generator

The block turns a first-octant phase code into an integer right-triangle triple (a, b, c) with a² + b² = c². The ratios a/c, b/c and a/b are the exact sine, cosine and tangent of an angle that lies within one phase step of the requested angle. No iteration is used. The upper phase bits pick a coarse triple from a table, together with a small non-positive correction that records how far that triple's angle falls short of the coarse target. The lower phase bits minus that correction form the address of a fine table of small-angle triples. The two triples are then joined by the angle-addition group law, a = a1·b2 + b1·a2, b = b1·b2 − a1·a2, c = c1·c2.

Both tables are computed at elaboration from the parameters, so no memory image is needed. A caller presents a code with a one-cycle valid strobe. The triple appears on registered outputs two clock edges later, and a new code may be accepted on every cycle. A downstream divider can then form fixed-point sine and cosine from the triple if they are needed.

Top module: `pyt_triple_gen`

## Requirements
- R1: A phase code present while inValid is high at a rising edge produces its triple and a one-cycle outValid pulse after the second following rising edge. The code is 14 bits, one step is π/65536 rad, and the full range covers 0 to π/4.
- R2: outValid is high only in the cycles set by R1. While outValid is low, outA, outB and outC keep their last values.
- R3: Every result satisfies outA² + outB² = outC² exactly, with outC > 0.
- R4: For every code p, atan(outA/outB) lies within one phase step of p·π/65536.
- R5: Code 0 yields the triple (0, 1, 1).
- R6: For codes below 128 the coarse triple is (0, 1, 1), so the output equals the fine triple for address p. Fine address f ≥ 1 has angle θ = f·π/65536 and x = 1/tan θ. Candidate A is (2u+1, 2u²+2u, 2u²+2u+1) with u = max(1, floor(x)). Candidate B is (4v, 4v²−1, 4v²+1) with v = max(1, floor(x+0.5)). The chosen candidate is the one whose atan(a/b) is closer to θ, with A chosen on a tie. Address 0 holds (0, 1, 1).
- R7: Codes presented on consecutive cycles give results on consecutive cycles, in the same order, each correct by R3 and R4.
- R8: Reset drives outValid low and all three outputs to zero. A strobe that is high while reset is active produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe that loads phaseIn |
| phaseIn | input | 14 | Phase code, step π/65536, range [0, π/4) |
| outValid | output | 1 | High for one cycle when a new triple is on the outputs |
| outA | output | 54 | Triple side opposite the angle (sine numerator) |
| outB | output | 54 | Triple side adjacent to the angle (cosine numerator) |
| outC | output | 54 | Hypotenuse (common denominator) |

## Verification
A code accepted at one rising edge sits in the phase register after that edge, and its triple is registered at the next one. The result is therefore due in the second cycle after the strobe. The driver stamps each expected item with that due cycle and queues it. The monitor samples on the falling edge, pops the oldest item whenever outValid is high, and fails any result that arrives off its stamp, so the timing of R1 and the ordering of R7 are checked on every result. The triple values are judged against the exact identity, the angle tolerance and the independently computed fine-table rule. In idle cycles the monitor checks that the outputs have not moved.

// File: rtl/pyt_pkg.sv
package pyt_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic loadPhase;
    logic loadOut;
  } pyt_strobe_t;

  localparam real PI_VAL = 3.14159265358979323846;

endpackage

// File: rtl/pyt_coarse_rom.sv
module pyt_coarse_rom #(
  parameter int PHASE_W = 14,
  parameter int LOW_W   = 7,
  parameter int N_MAX   = 64,
  parameter int M_MAX   = 1000,
  parameter int CW      = 21,
  parameter int DW      = 9
) (
  input  logic [PHASE_W-LOW_W-1:0] addr,
  output logic [CW-1:0]            a1,
  output logic [CW-1:0]            b1,
  output logic [CW-1:0]            c1,
  output logic signed [DW-1:0]     delta
);

  localparam int HIGH_W = PHASE_W - LOW_W;
  localparam int DEPTH  = 1 << HIGH_W;

  // Euclid pair (m, k) with the largest angle 2*atan(k/m) not above the target;
  // sel 0..2 give the sides, sel 3 the non-positive shortfall in phase steps.
  function automatic longint coarseField(input int idx, input int sel);
    real    lsb, target, t, ang, bestAng;
    longint m, bm, bk;
    lsb     = pyt_pkg::PI_VAL / (2.0 ** (PHASE_W + 2));
    target  = real'(idx) * real'(1 << LOW_W) * lsb;
    bestAng = 0.0;
    bm      = 1;
    bk      = 0;
    if (idx > 0) begin
      t = $tan(target / 2.0);
      for (int k = 1; k <= N_MAX; k++) begin
        m = longint'($ceil(real'(k) / t));
        if (m <= k) m = k + 1;
        ang = 2.0 * $atan(real'(k) / real'(m));
        if (ang > target) begin
          m   = m + 1;
          ang = 2.0 * $atan(real'(k) / real'(m));
        end
        if (m <= M_MAX && ang > bestAng) begin
          bestAng = ang;
          bm      = m;
          bk      = k;
        end
      end
    end
    case (sel)
      0:       return 2 * bm * bk;
      1:       return bm * bm - bk * bk;
      2:       return bm * bm + bk * bk;
      default: return -longint'($floor((target - bestAng) / lsb + 0.5));
    endcase
  endfunction

  logic [CW-1:0]        tabA [DEPTH];
  logic [CW-1:0]        tabB [DEPTH];
  logic [CW-1:0]        tabC [DEPTH];
  logic signed [DW-1:0] tabD [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam longint EA = coarseField(i, 0);
    localparam longint EB = coarseField(i, 1);
    localparam longint EC = coarseField(i, 2);
    localparam longint ED = coarseField(i, 3);
    assign tabA[i] = EA[CW-1:0];
    assign tabB[i] = EB[CW-1:0];
    assign tabC[i] = EC[CW-1:0];
    assign tabD[i] = ED[DW-1:0];
  end

  assign a1    = tabA[addr];
  assign b1    = tabB[addr];
  assign c1    = tabC[addr];
  assign delta = tabD[addr];

endmodule

// File: rtl/pyt_fine_rom.sv
module pyt_fine_rom #(
  parameter int PHASE_W = 14,
  parameter int FA_W    = 8,
  parameter int FW      = 32
) (
  input  logic [FA_W-1:0] addr,
  output logic [FW-1:0]   a2,
  output logic [FW-1:0]   b2,
  output logic [FW-1:0]   c2
);

  localparam int DEPTH = 1 << FA_W;

  // small-angle triple: two one-parameter families, the closer one wins
  function automatic longint fineField(input int f, input int sel);
    real    lsb, theta, x, errA, errB;
    longint u, v, aA, bA, aB, bB;
    if (f == 0) return (sel == 0) ? 64'd0 : 64'd1;
    lsb   = pyt_pkg::PI_VAL / (2.0 ** (PHASE_W + 2));
    theta = real'(f) * lsb;
    x     = 1.0 / $tan(theta);
    u     = longint'($floor(x));
    v     = longint'($floor(x + 0.5));
    if (u < 1) u = 1;
    if (v < 1) v = 1;
    aA   = 2 * u + 1;
    bA   = 2 * u * u + 2 * u;
    aB   = 4 * v;
    bB   = 4 * v * v - 1;
    errA = $atan2(real'(aA), real'(bA)) - theta;
    errB = $atan2(real'(aB), real'(bB)) - theta;
    if (errA < 0.0) errA = -errA;
    if (errB < 0.0) errB = -errB;
    if (errB < errA) begin
      case (sel)
        0:       return aB;
        1:       return bB;
        default: return bB + 2;
      endcase
    end
    case (sel)
      0:       return aA;
      1:       return bA;
      default: return bA + 1;
    endcase
  endfunction

  logic [FW-1:0] tabA [DEPTH];
  logic [FW-1:0] tabB [DEPTH];
  logic [FW-1:0] tabC [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam longint EA = fineField(i, 0);
    localparam longint EB = fineField(i, 1);
    localparam longint EC = fineField(i, 2);
    assign tabA[i] = EA[FW-1:0];
    assign tabB[i] = EB[FW-1:0];
    assign tabC[i] = EC[FW-1:0];
  end

  assign a2 = tabA[addr];
  assign b2 = tabB[addr];
  assign c2 = tabC[addr];

endmodule

// File: rtl/pyt_ctrl.sv
module pyt_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output pyt_pkg::pyt_strobe_t strobe,
  output logic                 outValid
);

  logic phaseValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      phaseValid <= inValid;
      outValid   <= phaseValid;
    end
  end

  always_comb begin
    strobe.loadPhase = inValid & ~rst;
    strobe.loadOut   = phaseValid;
  end

endmodule

// File: rtl/pyt_datapath.sv
module pyt_datapath #(
  parameter int PHASE_W = 14,
  parameter int LOW_W   = 7,
  parameter int N_MAX   = 64,
  parameter int M_MAX   = 1000,
  parameter int CW      = 21,
  parameter int FW      = 32,
  parameter int OUT_W   = CW + FW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pyt_pkg::pyt_strobe_t       strobe,
  input  logic [PHASE_W-1:0]         phaseIn,
  output logic [OUT_W-1:0]           outA,
  output logic [OUT_W-1:0]           outB,
  output logic [OUT_W-1:0]           outC,
  output logic signed [LOW_W+2:0]    fineSum
);

  localparam int HIGH_W = PHASE_W - LOW_W;
  localparam int DW     = LOW_W + 2;
  localparam int FS_W   = LOW_W + 3;
  localparam int FA_W   = LOW_W + 1;

  logic [PHASE_W-1:0]   phaseReg;
  logic [CW-1:0]        a1, b1, c1;
  logic signed [DW-1:0] delta;
  logic [FW-1:0]        a2, b2, c2;
  logic [FA_W-1:0]      fineAddr;

  always_ff @(posedge clk) begin
    if (rst)                   phaseReg <= '0;
    else if (strobe.loadPhase) phaseReg <= phaseIn;
  end

  pyt_coarse_rom #(
    .PHASE_W(PHASE_W), .LOW_W(LOW_W), .N_MAX(N_MAX),
    .M_MAX(M_MAX), .CW(CW), .DW(DW)
  ) uCoarse (
    .addr (phaseReg[PHASE_W-1 -: HIGH_W]),
    .a1   (a1),
    .b1   (b1),
    .c1   (c1),
    .delta(delta)
  );

  // correction adder: shortfall is non-positive, so the fine address only grows
  assign fineSum  = $signed({{(FS_W-LOW_W){1'b0}}, phaseReg[LOW_W-1:0]})
                  - $signed({delta[DW-1], delta});
  assign fineAddr = fineSum[FA_W-1:0];

  pyt_fine_rom #(
    .PHASE_W(PHASE_W), .FA_W(FA_W), .FW(FW)
  ) uFine (
    .addr(fineAddr),
    .a2  (a2),
    .b2  (b2),
    .c2  (c2)
  );

  // angle-addition combiner
  logic [OUT_W-1:0] xa1, xb1, xc1, xa2, xb2, xc2;
  logic [OUT_W-1:0] sumA, difB, prodC;

  always_comb begin
    xa1   = OUT_W'(a1);
    xb1   = OUT_W'(b1);
    xc1   = OUT_W'(c1);
    xa2   = OUT_W'(a2);
    xb2   = OUT_W'(b2);
    xc2   = OUT_W'(c2);
    sumA  = xa1 * xb2 + xb1 * xa2;
    difB  = xb1 * xb2 - xa1 * xa2;
    prodC = xc1 * xc2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outA <= '0;
      outB <= '0;
      outC <= '0;
    end else if (strobe.loadOut) begin
      outA <= sumA;
      outB <= difB;
      outC <= prodC;
    end
  end

endmodule

// File: rtl/pyt_triple_gen.sv
module pyt_triple_gen #(
  parameter int PHASE_W = 14,
  parameter int LOW_W   = 7,
  parameter int N_MAX   = 64,
  parameter int M_MAX   = 1000,
  parameter int FINE_W  = 32,
  localparam int CW     = 2 * $clog2(M_MAX) + 1,
  localparam int OUT_W  = CW + FINE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic               outValid,
  output logic [OUT_W-1:0]   outA,
  output logic [OUT_W-1:0]   outB,
  output logic [OUT_W-1:0]   outC
);

  pyt_pkg::pyt_strobe_t        strobe;
  logic signed [LOW_W+2:0]     fineSum;

  pyt_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pyt_datapath #(
    .PHASE_W(PHASE_W), .LOW_W(LOW_W), .N_MAX(N_MAX),
    .M_MAX(M_MAX), .CW(CW), .FW(FINE_W), .OUT_W(OUT_W)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .phaseIn(phaseIn),
    .outA   (outA),
    .outB   (outB),
    .outC   (outC),
    .fineSum(fineSum)
  );

endmodule

// File: rtl/pyt_triple_chk.sv
module pyt_triple_chk #(
  parameter int OUT_W = 54,
  parameter int FS_W  = 10,
  parameter int FA_W  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   inValid,
  input logic                   outValid,
  input logic [OUT_W-1:0]       outA,
  input logic [OUT_W-1:0]       outB,
  input logic [OUT_W-1:0]       outC,
  input logic signed [FS_W-1:0] fineSum
);

  localparam int SQ_W = 2 * OUT_W + 2;

  logic [SQ_W-1:0] sqA, sqB, sqC;
  assign sqA = SQ_W'(outA) * SQ_W'(outA);
  assign sqB = SQ_W'(outB) * SQ_W'(outB);
  assign sqC = SQ_W'(outC) * SQ_W'(outC);

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outA) && $stable(outB) && $stable(outC)));

  p_identity_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sqA + sqB == sqC && outC != '0));

  p_fine_range_r4: assert property (@(posedge clk) disable iff (rst)
    (fineSum >= 0) && (fineSum < FS_W'(1 << FA_W)));

endmodule

bind pyt_triple_gen pyt_triple_chk #(
  .OUT_W(OUT_W), .FS_W(LOW_W + 3), .FA_W(LOW_W + 1)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .outA    (outA),
  .outB    (outB),
  .outC    (outC),
  .fineSum (fineSum)
);

// File: tb/tb_pyt_triple_gen.sv
module tb_pyt_triple_gen;

  localparam int  OUT_W = 54;
  localparam real PI_R  = 3.14159265358979323846;
  localparam real LSB   = PI_R / 65536.0;

  typedef struct {
    int     code;
    longint due;
    string  tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [13:0]      phaseIn = '0;
  logic             outValid;
  logic [OUT_W-1:0] outA, outB, outC;

  int     total = 0;
  int     bad   = 0;
  longint cyc   = 0;
  item_t  q[$];
  logic [OUT_W-1:0] lastA = '0, lastB = '0, lastC = '0;
  bit     armed = 1'b0;

  pyt_triple_gen dut (
    .clk(clk), .rst(rst), .inValid(inValid), .phaseIn(phaseIn),
    .outValid(outValid), .outA(outA), .outB(outB), .outC(outC)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // fine-table rule as stated in the requirement on small codes
  task automatic fineRef(input int f, output longint ea, output longint eb, output longint ec);
    real theta, x, errA, errB;
    longint u, v;
    if (f == 0) begin ea = 0; eb = 1; ec = 1; return; end
    theta = real'(f) * LSB;
    x = 1.0 / $tan(theta);
    u = longint'($floor(x)); if (u < 1) u = 1;
    v = longint'($floor(x + 0.5)); if (v < 1) v = 1;
    errA = $atan2(real'(2*u+1), real'(2*u*u+2*u)) - theta;
    errB = $atan2(real'(4*v), real'(4*v*v-1)) - theta;
    if (errA < 0.0) errA = -errA;
    if (errB < 0.0) errB = -errB;
    if (errB < errA) begin ea = 4*v; eb = 4*v*v-1; ec = 4*v*v+1; end
    else begin ea = 2*u+1; eb = 2*u*u+2*u; ec = 2*u*u+2*u+1; end
  endtask

  task automatic send(input int code, input string tag);
    item_t it;
    phaseIn = code[13:0];
    inValid = 1'b1;
    it.code = code;
    it.due  = cyc + 2;
    it.tag  = tag;
    q.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && armed) begin
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", $sformatf("R2 outValid with nothing pending act=1 exp=0"));
        end else begin
          item_t it;
          logic [127:0] sa, sb, sc;
          real ang, tgt, err;
          longint ea, eb, ec;
          it = q.pop_front();
          check(it.due == cyc, "R1", $sformatf("code %0d due act=%0d exp=%0d", it.code, cyc, it.due));
          sa = 128'(outA) * 128'(outA);
          sb = 128'(outB) * 128'(outB);
          sc = 128'(outC) * 128'(outC);
          check(sa + sb == sc && outC != 0, "R3",
                $sformatf("code %0d a2+b2 act=%0d exp c2=%0d", it.code, sa + sb, sc));
          ang = $atan2(real'(outA), real'(outB));
          tgt = real'(it.code) * LSB;
          err = ang - tgt;
          if (err < 0.0) err = -err;
          check(err <= LSB, it.tag,
                $sformatf("code %0d angle act=%f exp=%f rad", it.code, ang, tgt));
          if (it.code < 128) begin
            fineRef(it.code, ea, eb, ec);
            check(outA == OUT_W'(ea) && outB == OUT_W'(eb) && outC == OUT_W'(ec),
                  (it.code == 0) ? "R5" : "R6",
                  $sformatf("code %0d act=(%0d,%0d,%0d) exp=(%0d,%0d,%0d)",
                            it.code, outA, outB, outC, ea, eb, ec));
          end
        end
        lastA = outA; lastB = outB; lastC = outC;
      end else begin
        check(outA == lastA && outB == lastB && outC == lastC, "R2",
              $sformatf("idle hold act=(%0d,%0d,%0d) exp=(%0d,%0d,%0d)",
                        outA, outB, outC, lastA, lastB, lastC));
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // strobe held high during reset must not yield a result (R8)
    inValid = 1'b1;
    phaseIn = 14'd10923;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    check(outValid == 1'b0 && outA == 0 && outB == 0 && outC == 0, "R8",
          $sformatf("reset state act=(%0d,%0d,%0d,%0d) exp=(0,0,0,0)", outValid, outA, outB, outC));
    armed = 1'b1;
    idle(4);

    // fine-only region and zero code
    send(0, "R5");     idle(3);
    send(1, "R6");     idle(2);
    send(2, "R6");     idle(1);
    send(50, "R6");
    send(127, "R6");   idle(3);

    // pi/6 and the top of the range
    send(10923, "R4"); idle(2);
    send(16383, "R4"); idle(2);
    send(128, "R4");   idle(2);

    // every coarse boundary, back to back
    for (int k = 0; k < 128; k++) send(k * 128, "R7");
    idle(4);

    // a full sweep of small codes back to back
    for (int k = 0; k < 128; k++) send(k, "R7");
    idle(4);

    // scattered codes with gaps
    for (int k = 0; k < 300; k++) begin
      send(int'($urandom_range(16383, 0)), "R4");
      if (k % 3 == 0) idle(k % 5);
    end

    while (q.size() > 0) @(negedge clk);
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule